// File: doc/BRIEF.md
# Significand Product Unit with Sticky Truncation

This block produces the unrounded product of two normalised 53-bit binary64 significands, as the multiply half of a fused multiply-add datapath. Each significand comes with its hidden bit set, an unbiased signed exponent and a sign bit. A negate control flips the sign of the product, which gives the subtract form of the fused operation. The block returns three things: the product sign, the exponent sum with any normalisation increment applied, and a 56-bit significand. That significand holds the hidden bit at bit 55, then 52 fraction bits, then guard, round and sticky. Rounding and the addend alignment belong to later stages.

Each operand is left-justified into a 64-bit word. The unit multiplies the two words from four 32x32 partial products and keeps only the upper 64 bits of the 128-bit result. Every discarded low bit is folded into bit 0 of the kept word. The unit then narrows that word to 56 bits with a sticky shift whose distance depends on whether the top product bit is set.

A small sequencer runs the work over several cycles. **ST_IDLE** waits with `in_ready` high. On an accepted request (transition *accept*) it moves to **ST_MULT**, where the four partial products are registered (transition *mult_done*). In **ST_FOLD** the partial products are summed and reduced to a sticky-marked 64-bit word (transition *fold_done*). In **ST_NORM** the normalising shift and exponent adjust are registered (transition *norm_done*). **ST_DONE** raises `out_valid` for one cycle and then returns to ST_IDLE (transition *release*). Result outputs hold their value until the next result is written.

Top module: `sigprod_core`

## Requirements
- R1: Both 53-bit significands are placed with their hidden bit at bit 63 of a 64-bit word, with zeros below. The product uses the upper 64 bits of the full 128-bit product of those words, including every carry out of the lower half.
- R2: If any bit of the lower 64 bits of the 128-bit product is 1, bit 0 of the kept 64-bit word is forced to 1.
- R3: When bit 63 of the kept word is 1, `res_sig` is kept bits 63..8, and `res_exp` equals `exp_a + exp_b + 1`.
- R4: When bit 63 of the kept word is 0, `res_sig` is kept bits 62..7, and `res_exp` equals `exp_a + exp_b`.
- R5: In both shifts, bit 0 of `res_sig` is the OR of the kept bit landing there and all kept bits shifted out below it.
- R6: `res_sign` equals `sign_a XOR sign_b XOR neg_prod`.
- R7: `exp_a` and `exp_b` are 12-bit two's complement values. `res_exp` is 14-bit two's complement and holds every sum, including -4096 and +4095, without wrapping.
- R8: Whenever `out_valid` is 1, bit 55 of `res_sig` is 1.
- R9: A request is accepted at a rising edge where `in_valid` and `in_ready` are both 1. `out_valid` is 1 for exactly one cycle, in the cycle after the fourth rising edge counted from the accepting edge as the first. `in_ready` is 0 from the accepting edge until `out_valid` has fallen. Any `in_valid` seen while `in_ready` is 0 is ignored and starts no result.
- R10: After reset, `in_ready` is 1, `out_valid` is 0, and `res_sig`, `res_exp` and `res_sign` are all zero.
- R11: `res_sig`, `res_exp` and `res_sign` change only at the edge that raises `out_valid`, and hold their value at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request carries valid operands |
| in_ready | output | 1 | Unit can accept a request |
| sig_a | input | 53 | First significand, hidden bit at bit 52 |
| sig_b | input | 53 | Second significand, hidden bit at bit 52 |
| exp_a | input | 12 | First unbiased exponent, two's complement |
| exp_b | input | 12 | Second unbiased exponent, two's complement |
| sign_a | input | 1 | First operand sign |
| sign_b | input | 1 | Second operand sign |
| neg_prod | input | 1 | Invert the product sign |
| out_valid | output | 1 | One-cycle pulse: result is ready |
| res_sign | output | 1 | Product sign |
| res_exp | output | 14 | Adjusted exponent sum, two's complement |
| res_sig | output | 56 | Normalised significand with guard, round and sticky |

## Verification
Each scenario drives its request half a cycle before the accepting edge. The pulse on `out_valid`, the significand, the exponent and the sign are all due after the fourth rising edge counted from that edge. The bench samples on the falling edges in between and expects `out_valid` low after the first three edges. It expects the pulse and all result values only after the fourth, and expects `out_valid` low again with `in_ready` back high after the fifth, with the results unchanged. The busy-time scenario keeps new operands on the inputs through the whole computation and then watches several more falling edges for a stray second pulse.

// File: rtl/sigprod_pkg.sv
package sigprod_pkg;

    // Default geometry of the binary64 significand product path
    localparam int unsigned SIG_W_DEF  = 53;
    localparam int unsigned HALF_W_DEF = 32;
    localparam int unsigned OUT_W_DEF  = 56;
    localparam int unsigned EXPI_W_DEF = 12;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_MULT = 3'd1,
        ST_FOLD = 3'd2,
        ST_NORM = 3'd3,
        ST_DONE = 3'd4
    } prod_state_e;

endpackage

// File: rtl/sigprod_pp.sv
// One half-word by half-word partial product.
module sigprod_pp #(
    parameter int unsigned HALF_W = 32
) (
    input  logic [HALF_W-1:0]   op_x,
    input  logic [HALF_W-1:0]   op_y,
    output logic [2*HALF_W-1:0] prod
);
    localparam int unsigned PW = 2 * HALF_W;

    always_comb begin
        prod = PW'(op_x) * PW'(op_y);
    end
endmodule

// File: rtl/sigprod_fold.sv
// Sums four partial products and keeps the upper word with a sticky mark.
module sigprod_fold #(
    parameter int unsigned HALF_W = 32
) (
    input  logic [2*HALF_W-1:0] pp_ll,
    input  logic [2*HALF_W-1:0] pp_lh,
    input  logic [2*HALF_W-1:0] pp_hl,
    input  logic [2*HALF_W-1:0] pp_hh,
    output logic [2*HALF_W-1:0] kept
);
    localparam int unsigned W2 = 2 * HALF_W;

    logic [W2:0]       cross_sum;   // lh + hl with its carry
    logic [W2:0]       low_sum;     // lower word plus carry out
    logic [W2-1:0]     high_sum;
    logic              low_nz;

    always_comb begin
        cross_sum = {1'b0, pp_lh} + {1'b0, pp_hl};
        low_sum   = {1'b0, pp_ll} + {1'b0, cross_sum[HALF_W-1:0], {HALF_W{1'b0}}};
        high_sum  = pp_hh
                  + W2'(cross_sum[W2:HALF_W])
                  + W2'(low_sum[W2]);
        low_nz    = |low_sum[W2-1:0];
        kept      = high_sum | W2'(low_nz);
    end
endmodule

// File: rtl/sigprod_norm.sv
// Picks one of two sticky right shifts depending on the top product bit.
module sigprod_norm #(
    parameter int unsigned WORD_W = 64,
    parameter int unsigned OUT_W  = 56
) (
    input  logic [WORD_W-1:0] kept,
    output logic [OUT_W-1:0]  sig,
    output logic              exp_inc
);
    localparam int unsigned SH_TOP = WORD_W - OUT_W;   // distance when bit 63 is set
    localparam int unsigned SH_BOT = SH_TOP - 1;       // distance otherwise

    logic [OUT_W-1:0] sig_top;
    logic [OUT_W-1:0] sig_bot;

    always_comb begin
        sig_top    = kept[WORD_W-1:SH_TOP];
        sig_top[0] = kept[SH_TOP] | (|kept[SH_TOP-1:0]);
        sig_bot    = kept[WORD_W-2:SH_BOT];
        sig_bot[0] = kept[SH_BOT] | (|kept[SH_BOT-1:0]);
        exp_inc    = kept[WORD_W-1];
        sig        = exp_inc ? sig_top : sig_bot;
    end
endmodule

// File: rtl/sigprod_core.sv
// Multi-cycle significand product with sticky truncation.
module sigprod_core
    import sigprod_pkg::*;
#(
    parameter int unsigned SIG_W  = SIG_W_DEF,
    parameter int unsigned HALF_W = HALF_W_DEF,
    parameter int unsigned OUT_W  = OUT_W_DEF,
    parameter int unsigned EXPI_W = EXPI_W_DEF
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    output logic                           in_ready,
    input  logic [SIG_W-1:0]               sig_a,
    input  logic [SIG_W-1:0]               sig_b,
    input  logic signed [EXPI_W-1:0]       exp_a,
    input  logic signed [EXPI_W-1:0]       exp_b,
    input  logic                           sign_a,
    input  logic                           sign_b,
    input  logic                           neg_prod,
    output logic                           out_valid,
    output logic                           res_sign,
    output logic signed [EXPI_W+1:0]       res_exp,
    output logic [OUT_W-1:0]               res_sig
);
    localparam int unsigned WORD_W = 2 * HALF_W;
    localparam int unsigned PAD_W  = WORD_W - SIG_W;
    localparam int unsigned EXPO_W = EXPI_W + 2;
    localparam int unsigned NPP    = 4;

    prod_state_e state_q, state_d;

    logic [WORD_W-1:0]        word_a_q, word_b_q;
    logic signed [EXPO_W-1:0] exp_sum_q;
    logic                     sign_q;
    logic [WORD_W-1:0]        pp_q   [NPP];
    logic [WORD_W-1:0]        pp_w   [NPP];
    logic [WORD_W-1:0]        kept_w, kept_q;
    logic [OUT_W-1:0]         norm_sig;
    logic                     norm_inc;
    logic                     accept;

    assign accept = in_valid && (state_q == ST_IDLE);

    // Partial products: index bit 1 picks the half of A, bit 0 the half of B
    for (genvar gi = 0; gi < NPP; gi++) begin : g_pp
        localparam int unsigned AH = (gi >> 1) & 1;
        localparam int unsigned BH = gi & 1;
        sigprod_pp #(.HALF_W(HALF_W)) i_pp (
            .op_x (word_a_q[AH*HALF_W +: HALF_W]),
            .op_y (word_b_q[BH*HALF_W +: HALF_W]),
            .prod (pp_w[gi])
        );
    end

    sigprod_fold #(.HALF_W(HALF_W)) i_fold (
        .pp_ll (pp_q[0]),
        .pp_lh (pp_q[1]),
        .pp_hl (pp_q[2]),
        .pp_hh (pp_q[3]),
        .kept  (kept_w)
    );

    sigprod_norm #(.WORD_W(WORD_W), .OUT_W(OUT_W)) i_norm (
        .kept    (kept_q),
        .sig     (norm_sig),
        .exp_inc (norm_inc)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_MULT;   // accept
            ST_MULT: state_d = ST_FOLD;               // mult_done
            ST_FOLD: state_d = ST_NORM;               // fold_done
            ST_NORM: state_d = ST_DONE;               // norm_done
            ST_DONE: state_d = ST_IDLE;               // release
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_a_q  <= '0;
            word_b_q  <= '0;
            exp_sum_q <= '0;
            sign_q    <= 1'b0;
            for (int k = 0; k < NPP; k++) pp_q[k] <= '0;
            kept_q    <= '0;
            res_sig   <= '0;
            res_exp   <= '0;
            res_sign  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    word_a_q  <= {sig_a, {PAD_W{1'b0}}};
                    word_b_q  <= {sig_b, {PAD_W{1'b0}}};
                    exp_sum_q <= EXPO_W'(exp_a) + EXPO_W'(exp_b);
                    sign_q    <= sign_a ^ sign_b ^ neg_prod;
                end
                ST_MULT: for (int k = 0; k < NPP; k++) pp_q[k] <= pp_w[k];
                ST_FOLD: kept_q <= kept_w;
                ST_NORM: begin
                    res_sig  <= norm_sig;
                    res_exp  <= exp_sum_q + $signed({{(EXPO_W-1){1'b0}}, norm_inc});
                    res_sign <= sign_q;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // Handshake outputs
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        out_valid = (state_q == ST_DONE);
    end
endmodule

// File: rtl/sigprod_core_chk.sv
module sigprod_core_chk #(
    parameter int unsigned EXPI_W = 12,
    parameter int unsigned OUT_W  = 56
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic signed [EXPI_W-1:0] exp_a,
    input logic signed [EXPI_W-1:0] exp_b,
    input logic                     sign_a,
    input logic                     sign_b,
    input logic                     neg_prod,
    input logic                     out_valid,
    input logic                     res_sign,
    input logic signed [EXPI_W+1:0] res_exp,
    input logic [OUT_W-1:0]         res_sig
);
    localparam int unsigned EXPO_W = EXPI_W + 2;

    logic                     cap_sign;
    logic signed [EXPO_W-1:0] cap_sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_sign <= 1'b0;
            cap_sum  <= '0;
        end else if (in_valid && in_ready) begin
            cap_sign <= sign_a ^ sign_b ^ neg_prod;
            cap_sum  <= EXPO_W'(exp_a) + EXPO_W'(exp_b);
        end
    end

    // R8
    hidden_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> res_sig[OUT_W-1]);

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R6
    product_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (res_sign == cap_sign));

    // R3
    exp_adjust_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((res_exp == cap_sum) || (res_exp == cap_sum + EXPO_W'(1))));

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(res_sig) && $stable(res_exp) && $stable(res_sign)));
endmodule

bind sigprod_core sigprod_core_chk #(.EXPI_W(EXPI_W), .OUT_W(OUT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .exp_a     (exp_a),
    .exp_b     (exp_b),
    .sign_a    (sign_a),
    .sign_b    (sign_b),
    .neg_prod  (neg_prod),
    .out_valid (out_valid),
    .res_sign  (res_sign),
    .res_exp   (res_exp),
    .res_sig   (res_sig)
);

// File: tb/test_sigprod_core.sv
`timescale 1ns/1ps
module test_sigprod_core;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [52:0]        sig_a = '0, sig_b = '0;
    logic signed [11:0] exp_a = '0, exp_b = '0;
    logic               sign_a = 1'b0, sign_b = 1'b0, neg_prod = 1'b0;
    logic               out_valid;
    logic               res_sign;
    logic signed [13:0] res_exp;
    logic [55:0]        res_sig;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sigprod_core i_sigprod_core (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .sig_a(sig_a), .sig_b(sig_b), .exp_a(exp_a), .exp_b(exp_b),
        .sign_a(sign_a), .sign_b(sign_b), .neg_prod(neg_prod),
        .out_valid(out_valid), .res_sign(res_sign), .res_exp(res_exp),
        .res_sig(res_sig)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    // Reference: {inc, sig} from the full 128-bit product (R1, R2, R3, R4, R5)
    function automatic logic [56:0] model(input logic [52:0] a, input logic [52:0] b);
        logic [127:0] p;
        logic [63:0]  k;
        logic [55:0]  s;
        p = {64'b0, a, 11'b0} * {64'b0, b, 11'b0};
        k = p[127:64] | {63'b0, |p[63:0]};
        if (k[63]) begin
            s = k[63:8]; s[0] = k[8] | (|k[7:0]);
            return {1'b1, s};
        end
        s = k[62:7]; s[0] = k[7] | (|k[6:0]);
        return {1'b0, s};
    endfunction

    logic [55:0]        last_sig;
    logic signed [13:0] last_exp;
    logic               last_sign;

    task automatic run_op(input logic [52:0] a, input logic [52:0] b,
                          input logic signed [11:0] ea, input logic signed [11:0] eb,
                          input logic sa, input logic sb, input logic ng,
                          input string tag, input bit busy_noise);
        logic [56:0]        m;
        logic signed [13:0] e_exp;
        logic               e_sign;
        m      = model(a, b);
        e_exp  = 14'(ea) + 14'(eb) + 14'(m[56]);
        e_sign = sa ^ sb ^ ng;
        @(negedge clk);
        sig_a = a; sig_b = b; exp_a = ea; exp_b = eb;
        sign_a = sa; sign_b = sb; neg_prod = ng; in_valid = 1'b1;
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            if (busy_noise) begin
                sig_a = ~a | 53'h10_0000_0000_0000; sig_b = 53'h1F_FFFF_FFFF_FFFF;
                exp_a = 12'sd100; sign_a = ~sa;
            end else in_valid = 1'b0;
            check(!out_valid, {tag, " R9 no early pulse"}, 64'(out_valid), 64'd0);
            check(!in_ready, {tag, " R9 busy"}, 64'(in_ready), 64'd0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid, {tag, " R9 pulse after 4th edge"}, 64'(out_valid), 64'd1);
        check(res_sig == m[55:0], {tag, " R1 R5 significand"}, 64'(res_sig), 64'(m[55:0]));
        check(res_sig[55], {tag, " R8 hidden bit"}, 64'(res_sig[55]), 64'd1);
        check(res_exp == e_exp, {tag, m[56] ? " R3 exponent" : " R4 exponent"},
              64'(res_exp), 64'(e_exp));
        check(res_sign == e_sign, {tag, " R6 sign"}, 64'(res_sign), 64'(e_sign));
        @(negedge clk);
        check(!out_valid && in_ready, {tag, " R9 one-cycle pulse"},
              64'({out_valid, in_ready}), 64'b01);
        check(res_sig == m[55:0] && res_exp == e_exp, {tag, " R11 hold"},
              64'(res_sig), 64'(m[55:0]));
        last_sig = m[55:0]; last_exp = e_exp; last_sign = e_sign;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(in_ready && !out_valid, "R10 handshake", 64'({in_ready, out_valid}), 64'b10);
        check(res_sig == '0 && res_exp == '0 && !res_sign, "R10 results zero",
              64'(res_sig), 64'd0);
    endtask

    task automatic t_unit_product();   // 1.0 * 1.0: top bit clear path
        run_op(53'h10_0000_0000_0000, 53'h10_0000_0000_0000, 12'sd3, -12'sd5,
               1'b0, 1'b0, 1'b0, "unit R4", 1'b0);
        check(last_sig == 56'h80_0000_0000_0000, "R4 exact 1.0", 64'(last_sig),
              64'h80_0000_0000_0000);
    endtask

    task automatic t_max_product();    // largest significands: top bit set
        run_op(53'h1F_FFFF_FFFF_FFFF, 53'h1F_FFFF_FFFF_FFFF, 12'sd2047, 12'sd2047,
               1'b1, 1'b0, 1'b0, "max R3 R7", 1'b0);
        check(last_exp == 14'sd4095, "R7 no wrap high", 64'(last_exp), 64'd4095);
    endtask

    task automatic t_low_sticky();     // only low-half bits feed the sticky
        run_op(53'h10_0000_0000_0001, 53'h10_0000_0000_0001, 12'sd0, 12'sd0,
               1'b0, 1'b0, 1'b1, "lowsticky R2", 1'b0);
        check(last_sig == 56'h80_0000_0000_0011, "R2 sticky from low half",
              64'(last_sig), 64'h80_0000_0000_0011);
    endtask

    task automatic t_carry_patterns();
        run_op(53'h1A_BCDE_F012_3457, 53'h13_5792_4680_ACE1, -12'sd12, 12'sd40,
               1'b1, 1'b1, 1'b1, "mixA R1", 1'b0);
        run_op(53'h1F_FFFF_FFFF_0000, 53'h10_0000_FFFF_FFFF, 12'sd1, 12'sd1,
               1'b0, 1'b1, 1'b0, "mixB R1 R5", 1'b0);
        run_op(53'h16_A09E_667F_3BCD, 53'h16_A09E_667F_3BCD, 12'sd0, -12'sd1,
               1'b1, 1'b0, 1'b1, "sqrt2 R3 R6", 1'b0);
    endtask

    task automatic t_exp_low();
        run_op(53'h11_1111_1111_1111, 53'h12_3456_789A_BCDE, -12'sd2048, -12'sd2048,
               1'b0, 1'b0, 1'b0, "explow R7", 1'b0);
        check(last_exp == -14'sd4096, "R7 no wrap low", 64'(last_exp), 64'(-14'sd4096));
    endtask

    task automatic t_busy_ignore();
        run_op(53'h18_0000_0000_0003, 53'h1C_0000_0000_0005, 12'sd7, 12'sd9,
               1'b0, 1'b1, 1'b0, "busy R9", 1'b1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(!out_valid, "R9 no second result", 64'(out_valid), 64'd0);
        end
        check(res_sig == last_sig && res_exp == last_exp && res_sign == last_sign,
              "R11 idle hold", 64'(res_sig), 64'(last_sig));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_unit_product();
        t_max_product();
        t_low_sticky();
        t_carry_patterns();
        t_exp_low();
        t_busy_ignore();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule